// File: doc/BRIEF.md
# Watchdog and Interval Timer

The block is an 8-bit up-counter driven from a free-running 17-bit clock divider. A 3-bit select field picks one of eight divider taps. Each tick of that tap advances the counter by one step. When the count wraps from its maximum back to zero, the block acts according to its mode. In interval mode it latches an overflow flag and raises a level interrupt request. In watchdog mode it raises a single-cycle system reset request instead, but only when the external reset-enable input is high.

Software reaches the control/status byte and the counter through a small register port. The port has a read strobe, a write strobe, a one-bit register select and a 16-bit write word. The upper byte of every write must carry the key value 0xA5, and a write with any other key leaves both registers unchanged. The overflow flag follows a two-step clear protocol. A read must first see the flag set, and a later write must then put 0 in the flag bit.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control/status byte reads 0x18, the counter reads 0x00, and both `irq_o` and `sys_rst_req_o` are low.
- R2: A write (addr 0 = control/status, addr 1 = counter) takes effect only when `wr_data_i[15:8]` equals 0xA5. Any other key leaves the addressed register unchanged.
- R3: Control/status layout: bit 7 is the overflow flag, bit 6 is the mode (1 = watchdog), bit 5 is the run enable, and bits 2:0 are the tap select. Bits 4 and 3 always read 1 and ignore writes. Writing 1 to bit 7 never sets the flag.
- R4: While the run enable is 0, the counter is held at 0x00 and counter writes have no effect.
- R5: While running, the counter advances once every 2^E system clocks, where E is 1, 6, 7, 9, 11, 13, 15 or 17 for select codes 0 to 7.
- R6: The overflow flag sets on the clock edge at which the counter wraps from 0xFF to 0x00.
- R7: The flag clears only when a keyed control write with bit 7 = 0 follows a control read that returned the flag as 1. A write without such a read leaves the flag set. Any keyed control write uses up the armed state.
- R8: When an overflow and a clearing write fall on the same edge, the flag stays set.
- R9: In interval mode, `irq_o` equals the overflow flag. In watchdog mode, `irq_o` is 0.
- R10: In watchdog mode with `rst_en_i` = 1, an overflow gives a one-cycle pulse on `sys_rst_req_o` and leaves the flag at 0. With `rst_en_i` = 0 the flag sets and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb_i | input | 1 | Read strobe for the addressed register |
| wr_stb_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 1 | Register select: 0 control/status, 1 counter |
| wr_data_i | input | 16 | Write word: key in upper byte, data in lower byte |
| rd_data_o | output | 8 | Read data of the addressed register |
| rst_en_i | input | 1 | Enables reset requests in watchdog mode |
| irq_o | output | 1 | Interval interrupt request (level) |
| sys_rst_req_o | output | 1 | Watchdog reset request (one-cycle pulse) |

## Verification
Two functions can fall in the same cycle: the wrap that sets the overflow flag, and the armed write that clears it. The bench arms the clear with a control read and then watches the counter at the fastest tap. When it sees the count step from 0xFE to 0xFF, it knows the next divider tick comes two edges later. It places the clearing write on exactly that edge. The flag must then still be set, which shows as `irq_o` held high. A later clear on its own must still work.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W  = 8;
    localparam int SEL_W  = 3;
    localparam int PRE_W  = 17;
    localparam int KEY_W  = 8;
    localparam logic [KEY_W-1:0] WR_KEY = 8'hA5;

    typedef enum logic {
        REG_CTL = 1'b0,
        REG_CNT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             ovf;
        logic             wdog;
        logic             run;
        logic [1:0]       rsvd;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    // divider exponent for each select code
    function automatic int tap_exp(input int code);
        case (code)
            0:       return 1;
            1:       return 6;
            2:       return 7;
            3:       return 9;
            4:       return 11;
            5:       return 13;
            6:       return 15;
            default: return 17;
        endcase
    endfunction

    // low-bit mask whose all-ones state marks one tick of a tap
    function automatic logic [31:0] tap_mask(input int code);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            m[i] = (i < tap_exp(code));
        end
        return m;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int DIV_W = PRE_W,
    parameter int SW    = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sel_i,
    output logic          tick_o
);
    localparam int NTAP = 1 << SW;

    logic [DIV_W-1:0] div_q;
    logic [NTAP-1:0]  hit;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        localparam logic [31:0]      MASK32 = tap_mask(g);
        localparam logic [DIV_W-1:0] MASK   = MASK32[DIV_W-1:0];
        assign hit[g] = ((div_q & MASK) == MASK);
    end

    assign tick_o = hit[sel_i];

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i)  cnt_q <= '0;
        else if (ld_i)      cnt_q <= ld_val_i;
        else if (tick_i)    cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = run_i && !ld_i && tick_i && (cnt_q == TOP);

    // R4
    halt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> cnt_o == '0);

    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        run_i && !ld_i && !tick_i |=> $stable(cnt_o));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> cnt_o == '0);

endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_ctl_i,
    input  logic             wr_ctl_i,
    input  logic             wr_flag_i,
    input  logic             wr_wdog_i,
    input  logic             wr_run_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic             wrap_i,
    input  logic             rst_en_i,
    output ctl_t             ctl_o,
    output logic             irq_o,
    output logic             rst_req_o
);
    logic             flag_q, wdog_q, run_q, armed_q, req_q;
    logic [SEL_W-1:0] sel_q;
    logic             clear_ok, int_rst;

    assign clear_ok = wr_ctl_i && !wr_flag_i && armed_q;
    assign int_rst  = wrap_i && wdog_q && rst_en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            wdog_q  <= 1'b0;
            run_q   <= 1'b0;
            sel_q   <= '0;
            armed_q <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            // overflow outranks a clearing write; a watchdog reset wipes the flag
            if (int_rst)       flag_q <= 1'b0;
            else if (wrap_i)   flag_q <= 1'b1;
            else if (clear_ok) flag_q <= 1'b0;

            if (wr_ctl_i) begin
                wdog_q <= wr_wdog_i;
                run_q  <= wr_run_i;
                sel_q  <= wr_sel_i;
            end

            if (wr_ctl_i)                armed_q <= 1'b0;
            else if (rd_ctl_i && flag_q) armed_q <= 1'b1;

            req_q <= int_rst;
        end
    end

    always_comb begin
        ctl_o.ovf  = flag_q;
        ctl_o.wdog = wdog_q;
        ctl_o.run  = run_q;
        ctl_o.rsvd = '1;
        ctl_o.sel  = sel_q;
    end

    assign irq_o     = flag_q && !wdog_q;
    assign rst_req_o = req_q;

    // R6
    flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_o.ovf) |-> $past(wrap_i));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_o.ovf) |-> ($past(wr_ctl_i && !wr_flag_i) || $past(wrap_i && rst_en_i)));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_i && !(ctl_o.wdog && rst_en_i) |=> ctl_o.ovf);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_o.wdog |-> !irq_o);

    // R10
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> !rst_req_o);

    // R10
    req_src_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> $past(wrap_i && rst_en_i));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = PRE_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_stb_i,
    input  logic        wr_stb_i,
    input  logic        addr_i,
    input  logic [15:0] wr_data_i,
    output logic [7:0]  rd_data_o,
    input  logic        rst_en_i,
    output logic        irq_o,
    output logic        sys_rst_req_o
);
    reg_sel_e   rsel;
    logic       key_ok, wr_ctl, rd_ctl, ld_cnt, tick, wrap;
    ctl_t       ctl;
    ctl_t       wr_fields;
    logic [CW-1:0] cnt;

    assign rsel      = reg_sel_e'(addr_i);
    assign key_ok    = (wr_data_i[15:8] == WR_KEY);
    assign wr_ctl    = wr_stb_i && key_ok && (rsel == REG_CTL);
    assign ld_cnt    = wr_stb_i && key_ok && (rsel == REG_CNT);
    assign rd_ctl    = rd_stb_i && (rsel == REG_CTL);
    assign wr_fields = ctl_t'(wr_data_i[7:0]);

    wdt_prescaler #(.DIV_W(DW), .SW(SEL_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (ctl.sel),
        .tick_o (tick)
    );

    wdt_counter #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run_i    (ctl.run),
        .tick_i   (tick),
        .ld_i     (ld_cnt),
        .ld_val_i (wr_data_i[CW-1:0]),
        .cnt_o    (cnt),
        .wrap_o   (wrap)
    );

    wdt_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .rd_ctl_i  (rd_ctl),
        .wr_ctl_i  (wr_ctl),
        .wr_flag_i (wr_fields.ovf),
        .wr_wdog_i (wr_fields.wdog),
        .wr_run_i  (wr_fields.run),
        .wr_sel_i  (wr_fields.sel),
        .wrap_i    (wrap),
        .rst_en_i  (rst_en_i),
        .ctl_o     (ctl),
        .irq_o     (irq_o),
        .rst_req_o (sys_rst_req_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rsel == REG_CNT) rd_data_o[CW-1:0] = cnt;
        else                 rd_data_o = ctl;
    end

    // R2
    key_guard_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_i && !key_ok |=> $stable({ctl.wdog, ctl.run, ctl.sel}));

    // R3
    rsvd_ones_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.rsvd == 2'b11);

endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic        addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rst_en = 1'b0;
    logic [7:0]  rd_data;
    logic        irq, rst_req;

    int tests = 0;
    int fails = 0;
    int req_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wdog_timer i_wdog_timer (
        .clk           (clk),
        .rst           (rst),
        .rd_stb_i      (rd_stb),
        .wr_stb_i      (wr_stb),
        .addr_i        (addr),
        .wr_data_i     (wr_data),
        .rd_data_o     (rd_data),
        .rst_en_i      (rst_en),
        .irq_o         (irq),
        .sys_rst_req_o (rst_req)
    );

    always @(negedge clk) if (rst_req) req_cnt++;

    // key, data, expected control readback
    localparam logic [23:0] VEC [0:4] = '{
        24'hA5_62_7A,
        24'h5A_00_7A,
        24'hA5_9F_1F,
        24'h00_45_1F,
        24'hA5_00_18
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [15:0] w);
        @(negedge clk);
        addr = a; wr_data = w; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL timeout: run did not complete (all requirements)");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v, a0, b0, prev;
        bit found;

        do_reset();

        // R1 reset state
        bus_read(1'b0, v); chk("R1 ctl", v, 8'h18);
        bus_read(1'b1, v); chk("R1 cnt", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 req", {7'd0, rst_req}, 8'h00);

        // R2 R3 keyed writes and field layout
        for (int i = 0; i < 5; i++) begin
            bus_write(1'b0, VEC[i][23:8]);
            bus_read(1'b0, v);
            chk("R2 R3 vector", v, VEC[i][7:0]);
        end

        // R4 counter write while halted
        bus_write(1'b1, 16'hA555);
        bus_read(1'b1, v); chk("R4 halted write", v, 8'h00);

        // R2 counter guarded write (slowest tap, running)
        bus_write(1'b0, 16'hA527);
        bus_write(1'b1, 16'hA580);
        bus_read(1'b1, v); chk("R2 cnt keyed", v, 8'h80);
        bus_write(1'b1, 16'h3311);
        bus_read(1'b1, v); chk("R2 cnt bad key", v, 8'h80);
        bus_write(1'b0, 16'hA507);
        bus_read(1'b1, v); chk("R4 stop clears", v, 8'h00);

        // R5 rates for codes 0, 1, 2
        bus_write(1'b0, 16'hA520);
        @(negedge clk); addr = 1'b1; #1 a0 = rd_data;
        idle(100); #1 b0 = rd_data;
        chk("R5 code0", b0 - a0, 8'd50);
        bus_write(1'b0, 16'hA521);
        @(negedge clk); addr = 1'b1; #1 a0 = rd_data;
        idle(640); #1 b0 = rd_data;
        chk("R5 code1", b0 - a0, 8'd10);
        bus_write(1'b0, 16'hA522);
        @(negedge clk); addr = 1'b1; #1 a0 = rd_data;
        idle(1280); #1 b0 = rd_data;
        chk("R5 code2", b0 - a0, 8'd10);

        // R6 R9 overflow period for code 1, interval mode
        do_reset();
        bus_write(1'b0, 16'hA521);
        idle(256*64 - 200);
        chk("R6 before wrap", {7'd0, irq}, 8'h00);
        idle(400);
        chk("R6 R9 after wrap irq", {7'd0, irq}, 8'h01);

        // R9 watchdog mode gates irq
        bus_write(1'b0, 16'hA561);
        chk("R9 gated", {7'd0, irq}, 8'h00);
        bus_write(1'b0, 16'hA521);
        chk("R9 restored", {7'd0, irq}, 8'h01);

        // R7 clear protocol
        bus_write(1'b0, 16'hA521);
        chk("R7 no read", {7'd0, irq}, 8'h01);
        bus_read(1'b0, v);
        chk("R7 read flag", v & 8'h80, 8'h80);
        bus_write(1'b0, 16'hA5A1);
        chk("R7 write one", {7'd0, irq}, 8'h01);
        bus_write(1'b0, 16'hA521);
        chk("R7 not armed", {7'd0, irq}, 8'h01);
        bus_read(1'b0, v);
        bus_write(1'b0, 16'hA521);
        chk("R7 cleared", {7'd0, irq}, 8'h00);

        // R8 overflow on the same edge as a clearing write
        do_reset();
        bus_write(1'b0, 16'hA520);
        found = 0;
        for (int k = 0; k < 1200 && !found; k++) begin
            @(negedge clk); #1 if (irq) found = 1;
        end
        chk("R8 first ovf", {7'd0, irq}, 8'h01);
        bus_read(1'b0, v);
        @(negedge clk); addr = 1'b1; #1 prev = rd_data;
        found = 0;
        for (int k = 0; k < 1200 && !found; k++) begin
            @(negedge clk); #1 v = rd_data;
            if (prev == 8'hFE && v == 8'hFF) found = 1;
            prev = v;
        end
        @(negedge clk);
        addr = 1'b0; wr_data = 16'hA520; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        #1 chk("R8 set wins", {7'd0, irq}, 8'h01);
        bus_read(1'b0, v);
        bus_write(1'b0, 16'hA520);
        chk("R8 later clear", {7'd0, irq}, 8'h00);

        // R10 watchdog reset request
        do_reset();
        rst_en = 1'b1;
        req_cnt = 0;
        bus_write(1'b0, 16'hA560);
        idle(600);
        chk("R10 one pulse", req_cnt[7:0], 8'd1);
        bus_read(1'b0, v);
        chk("R10 flag clear", v & 8'h80, 8'h00);
        rst_en = 1'b0;
        req_cnt = 0;
        idle(600);
        chk("R10 no request", req_cnt[7:0], 8'd0);
        bus_read(1'b0, v);
        chk("R10 flag set", v & 8'h80, 8'h80);
        chk("R9 wd irq low", {7'd0, irq}, 8'h00);

        done = 1;
        summary();
        $finish;
    end

endmodule